// File: doc/BRIEF.md
# SDRAM Controller with Refresh Timer

This block drives one rank of four-bank synchronous DRAM with a 13-bit row, a 9-bit column and a 2-bit bank address. It brings the memory up, keeps it refreshed and turns single-word host reads and writes into closed-page command sequences. Every access activates its row, issues the column command with auto-precharge, and then waits until the row cycle has finished. All spacing limits are given in nanoseconds and are converted to whole clocks, rounding up.

The host port uses valid/ready. A request is taken on a clock where `req_valid` and `req_ready` are both high. While `req_valid` is high and `req_ready` is low, the host must hold the address, write flag, data and byte enables steady. `req_ready` stays low during initialization, during an access, and while a refresh is pending. Read data comes back on `rsp_valid`/`rsp_rdata` as a one-cycle pulse with no back-pressure, in request order.

The memory data bus is split into a driven half (`sd_dq_out`, `sd_dq_oe`) and a sampled half (`sd_dq_in`). All command pins leave the block from registers.

Top module: `sdram_ctrl`

## Requirements
- R1: While reset is held, `sd_cs_n` is 1, `sd_dq_oe` is 0, `req_ready` is 0 and `rsp_valid` is 0.
- R2: Initialization runs in a fixed order, and no other command and no `req_ready` appear before it ends.
  - First, no command for at least INIT_CYC clocks.
  - Then one precharge-all.
  - Then two auto-refresh commands, the second at least a row cycle after the first.
  - Last, one mode-register write whose address word has bits[2:0]=000 (burst length 1), bit3=0 (sequential order), bits[6:4]=CAS latency and all other bits 0.
- R3: The host word address is split as row=addr[23:11], bank=addr[10:9] and column=addr[8:0].
  - The activate command carries the row on `sd_addr` and the bank on `sd_ba`.
  - The read or write command carries the column on `sd_addr[8:0]` and drives `sd_addr[10]`=1 (auto-precharge).
- R4: The controller takes each request exactly once, producing one activate and one column command per request. `req_ready` is low in the cycle after an acceptance.
- R5: A write drives `sd_dq_oe`=1 with the write data in the same cycle as the write command, and only then. In that cycle `sd_dqm[i]` equals the inverse of byte enable i (write mask latency 0).
- R6: Read data is sampled from `sd_dq_in` CAS-latency clocks after the memory samples the read command. It is presented on `rsp_rdata` with a one-cycle `rsp_valid`, in request order.
- R7: Command encodings on {cs_n,ras_n,cas_n,we_n} are 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 refresh, 0000 mode write and 0111 no-op. Spacing in whole clocks (all limits rounded up) is:
  - activate to column command: at least tRCD;
  - activate to activate: at least tRC;
  - precharge to activate or refresh: at least tRP;
  - refresh to the next activate or refresh: at least tRC;
  - write to the next activate: at least write recovery plus tRP;
  - mode write to the next command: at least 2.
- R8: After initialization, every auto-refresh comes after a precharge-all issued after the last activate. The gap between consecutive refreshes is at most the refresh interval (7.8 µs in clocks) plus 20 clocks.
- R9: Once a refresh is pending, no new activate is issued until that refresh has been sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller takes the request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Word address {row, bank, column} |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables for write |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data |
| sd_cs_n | output | 1 | Chip select, low active |
| sd_ras_n | output | 1 | Row strobe, low active |
| sd_cas_n | output | 1 | Column strobe, low active |
| sd_we_n | output | 1 | Write enable, low active |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Multiplexed row/column address |
| sd_dqm | output | 2 | Byte data masks |
| sd_dq_out | output | 16 | Data to memory |
| sd_dq_oe | output | 1 | Drive enable for sd_dq_out |
| sd_dq_in | input | 16 | Data from memory |

## Verification
The bench drives host traffic with several different patterns:
- writes with each of the four byte-enable patterns, which separate correct masking from a mask that is inverted, shifted or one cycle late;
- addresses at the lowest and highest word and with only the bank bits changed, which expose a wrong row/bank/column split;
- back-to-back write-then-read on the same word, which exercises read capture at exactly the CAS-latency cycle;
- long idle stretches mixed with traffic, so that refresh is seen both on a quiet controller and on one where a request is pending when the refresh interval expires.

A behavioural memory in the bench checks the spacing of every command pair it sees.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_MRS
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    S_PWR, S_IPRE, S_IREF, S_MRS, S_IDLE, S_COL, S_RPRE, S_RREF
  } sdr_state_e;

  // {ras_n, cas_n, we_n} for each command
  function automatic logic [2:0] cmd_pins(sdr_cmd_e c);
    case (c)
      CMD_ACT: return 3'b011;
      CMD_RD:  return 3'b101;
      CMD_WR:  return 3'b100;
      CMD_PRE: return 3'b010;
      CMD_REF: return 3'b001;
      CMD_MRS: return 3'b000;
      default: return 3'b111;
    endcase
  endfunction

  function automatic int ceil_div(int num, int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
  parameter int REFI_CYC = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic ack_i,
  output logic pend_o
);
  localparam int CW = $clog2(REFI_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(REFI_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = run_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_o <= 1'b0;
    end else begin
      if (!run_i || wrap) cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
      pend_o <= (pend_o && !ack_i) || wrap;
    end
  end

  // R8: a pending refresh stays pending until it is served
  a_r8_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !ack_i) |=> pend_o);

endmodule

// File: rtl/sdr_rd_capture.sv
module sdr_rd_capture #(
  parameter int CAS_LAT = 3,
  parameter int DW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_cmd_q,
  input  logic [DW-1:0] dq_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o
);
  // stage j is high j+1 clocks after the read command leaves the pins
  logic [CAS_LAT-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q     <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      stage_q     <= {stage_q[CAS_LAT-2:0], rd_cmd_q};
      rsp_valid_o <= stage_q[CAS_LAT-1];
      if (stage_q[CAS_LAT-1]) rsp_rdata_o <= dq_i;
    end
  end

  // R6: reads are at least a row cycle apart, so responses never run back to back
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |=> !rsp_valid_o);

endmodule

// File: rtl/sdr_seq.sv
module sdr_seq
  import sdr_pkg::*;
#(
  parameter int ROW_W    = 13,
  parameter int BANK_W   = 2,
  parameter int COL_W    = 9,
  parameter int DW       = 16,
  parameter int INIT_CYC = 50,
  parameter int C_RCD    = 2,
  parameter int C_RP     = 2,
  parameter int C_RC     = 7,
  parameter int C_POST_R = 5,
  parameter int C_POST_W = 5,
  parameter int C_MRD    = 2,
  parameter int CAS_LAT  = 3,
  localparam int AW      = ROW_W + BANK_W + COL_W,
  localparam int BW      = DW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DW-1:0]     req_wdata_i,
  input  logic [BW-1:0]     req_be_i,
  input  logic              ref_pend_i,
  output logic              ref_ack_o,
  output logic              run_o,
  output sdr_cmd_e          cmd_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ROW_W-1:0]  addr_o,
  output logic [BW-1:0]     dqm_o,
  output logic [DW-1:0]     wdata_o,
  output logic              oe_o
);
  localparam int GAP_MAX = imax(imax(INIT_CYC, C_RC), imax(C_POST_W, C_POST_R));
  localparam int TW      = $clog2(GAP_MAX + 1);
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);

  typedef struct packed {
    logic              wr;
    logic [ROW_W-1:0]  row;
    logic [BANK_W-1:0] bank;
    logic [COL_W-1:0]  col;
    logic [DW-1:0]     data;
    logic [BW-1:0]     be;
  } sdr_req_t;

  sdr_state_e st_q, st_n;
  logic [TW-1:0] tmr_q, tmr_n;
  logic          second_q, second_n;
  sdr_req_t      req_q, req_n;
  logic          tzero;

  assign tzero = (tmr_q == '0);
  assign run_o = (st_q == S_IDLE) || (st_q == S_COL) ||
                 (st_q == S_RPRE) || (st_q == S_RREF);

  always_comb begin
    st_n        = st_q;
    tmr_n       = tzero ? tmr_q : tmr_q - 1'b1;
    second_n    = second_q;
    req_n       = req_q;
    cmd_o       = CMD_NOP;
    ba_o        = '0;
    addr_o      = '0;
    dqm_o       = '0;
    wdata_o     = '0;
    oe_o        = 1'b0;
    ref_ack_o   = 1'b0;
    req_ready_o = 1'b0;
    case (st_q)
      S_PWR: if (tzero) st_n = S_IPRE;
      S_IPRE: if (tzero) begin
        cmd_o = CMD_PRE; addr_o[10] = 1'b1;
        tmr_n = TW'(C_RP - 1); st_n = S_IREF;
      end
      S_IREF: if (tzero) begin
        cmd_o = CMD_REF; tmr_n = TW'(C_RC - 1);
        second_n = 1'b1;
        if (second_q) st_n = S_MRS;
      end
      S_MRS: if (tzero) begin
        cmd_o = CMD_MRS; addr_o = MODE_WORD;
        tmr_n = TW'(C_MRD - 1); st_n = S_IDLE;
      end
      S_IDLE: if (tzero) begin
        if (ref_pend_i) st_n = S_RPRE;
        else begin
          req_ready_o = 1'b1;
          if (req_valid_i) begin
            req_n = '{wr: req_write_i,
                      row: req_addr_i[AW-1 -: ROW_W],
                      bank: req_addr_i[COL_W +: BANK_W],
                      col: req_addr_i[COL_W-1:0],
                      data: req_wdata_i, be: req_be_i};
            cmd_o  = CMD_ACT;
            ba_o   = req_addr_i[COL_W +: BANK_W];
            addr_o = req_addr_i[AW-1 -: ROW_W];
            tmr_n  = TW'(C_RCD - 1);
            st_n   = S_COL;
          end
        end
      end
      S_COL: if (tzero) begin
        ba_o = req_q.bank;
        addr_o[COL_W-1:0] = req_q.col;
        addr_o[10] = 1'b1;
        if (req_q.wr) begin
          cmd_o = CMD_WR; oe_o = 1'b1;
          wdata_o = req_q.data; dqm_o = ~req_q.be;
          tmr_n = TW'(C_POST_W - 1);
        end else begin
          cmd_o = CMD_RD;
          tmr_n = TW'(C_POST_R - 1);
        end
        st_n = S_IDLE;
      end
      S_RPRE: if (tzero) begin
        cmd_o = CMD_PRE; addr_o[10] = 1'b1;
        tmr_n = TW'(C_RP - 1); st_n = S_RREF;
      end
      S_RREF: if (tzero) begin
        cmd_o = CMD_REF; ref_ack_o = 1'b1;
        tmr_n = TW'(C_RC - 1); st_n = S_IDLE;
      end
      default: st_n = S_PWR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= S_PWR;
      tmr_q    <= TW'(INIT_CYC - 1);
      second_q <= 1'b0;
      req_q    <= '0;
    end else begin
      st_q     <= st_n;
      tmr_q    <= tmr_n;
      second_q <= second_n;
      req_q    <= req_n;
    end
  end

  // R9: no activation while a refresh is waiting
  a_r9_no_act_on_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_ACT) |-> !ref_pend_i);
  // R4: an accepted request closes the port for the next cycle
  a_r4_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

endmodule

// File: rtl/sdram_ctrl.sv
module sdram_ctrl
  import sdr_pkg::*;
#(
  parameter int CLK_NS    = 10,
  parameter int TRCD_NS   = 20,
  parameter int TRP_NS    = 20,
  parameter int TRAS_NS   = 50,
  parameter int TRC_NS    = 70,
  parameter int TREFI_NS  = 7800,
  parameter int WR_CYC    = 2,
  parameter int INIT_CYC  = 50,
  parameter int CAS_LAT   = 3,
  parameter int ROW_W     = 13,
  parameter int BANK_W    = 2,
  parameter int COL_W     = 9,
  parameter int DW        = 16,
  localparam int AW       = ROW_W + BANK_W + COL_W,
  localparam int BW       = DW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [BW-1:0]     req_be,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_addr,
  output logic [BW-1:0]     sd_dqm,
  output logic [DW-1:0]     sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [DW-1:0]     sd_dq_in
);
  localparam int C_RCD    = ceil_div(TRCD_NS, CLK_NS);
  localparam int C_RP     = ceil_div(TRP_NS, CLK_NS);
  localparam int C_RAS    = ceil_div(TRAS_NS, CLK_NS);
  localparam int C_RC     = ceil_div(TRC_NS, CLK_NS);
  localparam int C_REFI   = TREFI_NS / CLK_NS;
  localparam int C_POST_R = imax(imax(C_RC - C_RCD, C_RAS - C_RCD + C_RP), 1);
  localparam int C_POST_W = imax(C_POST_R, WR_CYC + C_RP);

  logic              ref_pend, ref_ack, run;
  sdr_cmd_e          cmd_n;
  logic [BANK_W-1:0] ba_n;
  logic [ROW_W-1:0]  addr_n;
  logic [BW-1:0]     dqm_n;
  logic [DW-1:0]     wdata_n;
  logic              oe_n, rd_q;

  sdr_refresh_timer #(.REFI_CYC(C_REFI)) u_refresh (
    .clk(clk), .rst_n(rst_n), .run_i(run), .ack_i(ref_ack), .pend_o(ref_pend));

  sdr_seq #(
    .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .DW(DW),
    .INIT_CYC(INIT_CYC), .C_RCD(C_RCD), .C_RP(C_RP), .C_RC(C_RC),
    .C_POST_R(C_POST_R), .C_POST_W(C_POST_W), .C_MRD(2), .CAS_LAT(CAS_LAT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .ref_pend_i(ref_pend), .ref_ack_o(ref_ack), .run_o(run),
    .cmd_o(cmd_n), .ba_o(ba_n), .addr_o(addr_n), .dqm_o(dqm_n),
    .wdata_o(wdata_n), .oe_o(oe_n));

  sdr_rd_capture #(.CAS_LAT(CAS_LAT), .DW(DW)) u_rdcap (
    .clk(clk), .rst_n(rst_n), .rd_cmd_q(rd_q), .dq_i(sd_dq_in),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sd_cs_n <= 1'b1;
      {sd_ras_n, sd_cas_n, sd_we_n} <= 3'b111;
      sd_ba <= '0; sd_addr <= '0; sd_dqm <= '0;
      sd_dq_out <= '0; sd_dq_oe <= 1'b0; rd_q <= 1'b0;
    end else begin
      sd_cs_n <= 1'b0;
      {sd_ras_n, sd_cas_n, sd_we_n} <= cmd_pins(cmd_n);
      sd_ba <= ba_n; sd_addr <= addr_n; sd_dqm <= dqm_n;
      sd_dq_out <= wdata_n; sd_dq_oe <= oe_n;
      rd_q <= (cmd_n == CMD_RD);
    end
  end

  // R5: the data bus is driven only together with a write command
  a_r5_oe_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> (!sd_cs_n && sd_ras_n && !sd_cas_n && !sd_we_n));
  // R3: column commands always request auto-precharge
  a_r3_col_autopre: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_cs_n && sd_ras_n && !sd_cas_n) |-> sd_addr[10]);

endmodule

// File: tb/sdram_ctrl_bench.sv
module sdram_ctrl_bench;
  localparam int CLK_NS = 10;
  localparam int CL = 3;
  localparam int INIT_CYC = 50;
  localparam int C_RCD = (20 + CLK_NS - 1) / CLK_NS;
  localparam int C_RP  = (20 + CLK_NS - 1) / CLK_NS;
  localparam int C_RC  = (70 + CLK_NS - 1) / CLK_NS;
  localparam int C_WR  = 2;
  localparam int C_REFI = 7800 / CLK_NS;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic req_valid = 0, req_ready, req_write = 0;
  logic [23:0] req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic [1:0]  req_be = 0;
  logic rsp_valid; logic [15:0] rsp_rdata;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [1:0] sd_ba, sd_dqm; logic [12:0] sd_addr;
  logic [15:0] sd_dq_out, sd_dq_in = 0;

  sdram_ctrl #(.CLK_NS(CLK_NS), .INIT_CYC(INIT_CYC), .CAS_LAT(CL)) u_sdram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
    .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in));

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  typedef struct { int a; bit wr; logic [15:0] exp; } op_t;
  op_t ops_q[$];
  logic [15:0] exp_q[$];
  logic [15:0] shadow [int];
  logic [15:0] mem [int];
  logic [12:0] open_row [4];

  int cyc = 0, init_step = 0, nref_post = 0, rd_cnt = 0;
  int last_act = -1000, last_pre = -1000, last_ref = -1000, last_wr = -1000, last_mrs = -1000;
  logic [15:0] rd_val;

  // behavioural memory and protocol reference, evaluated on every clock
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(sd_cs_n && !sd_dq_oe && !req_ready && !rsp_valid, "R1", "reset outputs",
          {sd_cs_n, sd_dq_oe, req_ready, rsp_valid}, 4'b1000);
    end else begin
      logic [3:0] code;
      cyc++;
      code = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (rd_cnt > 0) begin
        rd_cnt--;
        if (rd_cnt == 0) sd_dq_in = rd_val;
      end
      if (rsp_valid) begin
        if (exp_q.size() == 0) chk(0, "R6", "unexpected response", rsp_rdata, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(rsp_rdata == e, "R6", "read data", rsp_rdata, e);
        end
      end
      if (init_step < 4 && req_ready) chk(0, "R2", "ready during init", 1, 0);
      if (sd_dq_oe || code == 4'b0100)
        chk(sd_dq_oe && code == 4'b0100, "R5", "oe with write", {sd_dq_oe, code}, 5'h14);
      if (init_step < 4 && code != 4'b0111 && code != 4'b1111) begin
        logic [3:0] want;
        want = (init_step == 0) ? 4'b0010 : (init_step == 3) ? 4'b0000 : 4'b0001;
        chk(code == want, "R2", "init order", code, want);
        if (init_step == 0) chk(cyc >= INIT_CYC, "R2", "power-up wait", cyc, INIT_CYC);
      end
      case (code)
        4'b0011: begin
          chk(cyc - last_act >= C_RC, "R7", "act-act", cyc - last_act, C_RC);
          chk(cyc - last_pre >= C_RP, "R7", "pre-act", cyc - last_pre, C_RP);
          chk(cyc - last_ref >= C_RC, "R7", "ref-act", cyc - last_ref, C_RC);
          chk(cyc - last_wr >= C_WR + C_RP, "R7", "wr-act", cyc - last_wr, C_WR + C_RP);
          chk(cyc - last_mrs >= 2, "R7", "mrs-act", cyc - last_mrs, 2);
          if (ops_q.size() == 0) chk(0, "R4", "activate without request", 1, 0);
          else begin
            chk(sd_addr == ops_q[0].a[23:11], "R3", "row", sd_addr, ops_q[0].a[23:11]);
            chk(sd_ba == ops_q[0].a[10:9], "R3", "bank", sd_ba, ops_q[0].a[10:9]);
          end
          open_row[sd_ba] = sd_addr;
          last_act = cyc;
        end
        4'b0101, 4'b0100: begin
          int key;
          key = {sd_ba, open_row[sd_ba], sd_addr[8:0]};
          chk(cyc - last_act >= C_RCD, "R7", "act-col", cyc - last_act, C_RCD);
          chk(sd_addr[10], "R3", "auto-precharge bit", sd_addr[10], 1);
          if (ops_q.size() == 0) chk(0, "R4", "column without request", 1, 0);
          else begin
            op_t o;
            o = ops_q.pop_front();
            chk(sd_addr[8:0] == o.a[8:0], "R3", "column", sd_addr[8:0], o.a[8:0]);
            chk(sd_we_n == !o.wr, "R4", "command kind", sd_we_n, !o.wr);
            if (!o.wr) exp_q.push_back(o.exp);
          end
          if (!sd_we_n) begin
            logic [15:0] old;
            old = mem.exists(key) ? mem[key] : 16'h0;
            mem[key] = {sd_dqm[1] ? old[15:8] : sd_dq_out[15:8],
                        sd_dqm[0] ? old[7:0]  : sd_dq_out[7:0]};
            last_wr = cyc;
          end else begin
            chk(sd_dqm == 2'b00, "R6", "read mask", sd_dqm, 0);
            rd_val = mem.exists(key) ? mem[key] : 16'h0;
            rd_cnt = CL;
          end
        end
        4'b0010: begin
          chk(sd_addr[10], "R8", "precharge-all", sd_addr[10], 1);
          chk(cyc - last_wr >= C_WR, "R7", "wr-pre", cyc - last_wr, C_WR);
          if (init_step == 0) init_step = 1;
          last_pre = cyc;
        end
        4'b0001: begin
          chk(cyc - last_pre >= C_RP, "R7", "pre-ref", cyc - last_pre, C_RP);
          chk(cyc - last_ref >= C_RC, "R7", "ref-ref", cyc - last_ref, C_RC);
          chk(last_pre > last_act, "R8", "precharge before refresh", last_pre, last_act);
          if (init_step == 1 || init_step == 2) init_step++;
          else if (init_step == 4) begin
            if (nref_post > 0)
              chk(cyc - last_ref <= C_REFI + 20, "R8", "refresh interval", cyc - last_ref, C_REFI + 20);
            nref_post++;
          end
          last_ref = cyc;
        end
        4'b0000: begin
          chk(sd_addr == 13'(CL << 4), "R2", "mode word", sd_addr, CL << 4);
          chk(cyc - last_ref >= C_RC, "R7", "ref-mrs", cyc - last_ref, C_RC);
          if (init_step == 3) init_step = 4;
          last_mrs = cyc;
        end
        default: ;
      endcase
    end
  end

  task automatic host_op(bit wr, logic [23:0] a, logic [15:0] d, logic [1:0] be);
    op_t o;
    logic [15:0] old;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    old = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
    o.a = int'(a); o.wr = wr;
    if (wr) begin
      o.exp = {be[1] ? d[15:8] : old[15:8], be[0] ? d[7:0] : old[7:0]};
      shadow[int'(a)] = o.exp;
    end else o.exp = old;
    ops_q.push_back(o);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    // R5: each byte-enable pattern, then read back
    host_op(1, 24'h000000, 16'hA1B2, 2'b11);
    host_op(1, 24'h000000, 16'h55CC, 2'b01);
    host_op(0, 24'h000000, 16'h0, 2'b00);
    host_op(1, 24'h000000, 16'h7700, 2'b10);
    host_op(1, 24'h000000, 16'hFFFF, 2'b00);
    host_op(0, 24'h000000, 16'h0, 2'b00);
    // R3: extremes and bank-only differences
    host_op(1, 24'hFFFFFF, 16'h1234, 2'b11);
    for (int b = 0; b < 4; b++) host_op(1, {13'h0ABC, 2'(b), 9'h155}, 16'(16'h1000 + b), 2'b11);
    for (int b = 0; b < 4; b++) host_op(0, {13'h0ABC, 2'(b), 9'h155}, 16'h0, 2'b00);
    host_op(0, 24'hFFFFFF, 16'h0, 2'b00);
    // R8: idle stretch spanning refreshes
    repeat (1700) @(negedge clk);
    // R9 / R6: back-to-back traffic across a refresh boundary
    for (int i = 0; i < 60; i++) begin
      logic [23:0] a;
      a = 24'(i * 24'h012345);
      host_op(1, a, 16'(i * 16'h0311 + 7), 2'(i % 4));
      host_op(0, a, 16'h0, 2'b00);
    end
    repeat (40) @(negedge clk);
    chk(exp_q.size() == 0 && ops_q.size() == 0, "R6", "all responses returned",
        exp_q.size() + ops_q.size(), 0);
    chk(nref_post >= 2, "R8", "refreshes after init", nref_post, 2);
    done = 1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule